// File: doc/BRIEF.md
# Biquinary Digit Counting Adder

This block adds two decimal digits and a carry-in where every digit is carried as a seven-bit biquinary code. The code has a two-wire range field that picks the lower half (0 to 4) or the upper half (5 to 9) of the decimal range. It also has a five-wire one-hot quinary field that picks the offset within that half. The adder has no per-bit adder. The accumulator holds the first operand as a range pair and a five-position ring. The second operand's half (a jump of five) is applied in one parallel step by swapping the range pair. Its offset and the carry-in are then applied as single-position rotations of the ring, one per clock. Every rotation that wraps the ring flips the range pair. A flip out of the upper half produces the carry-out.

Both operands are screened before any work starts. A field that does not have exactly one set wire marks the operation as corrupt. The block then finishes at once with an error flag and a clean zero result. A caller presents both digits with a start request while the block shows ready. It then waits for the single-cycle completion strobe, and the result stays on the outputs until the next accepted request.

Top module: `bq_digit_adder`

## Requirements
- R1: A digit is seven bits: bit 6 is the upper-half wire (values 5 to 9), bit 5 is the lower-half wire (values 0 to 4), and bits 4:0 are a one-hot offset where bit i set means offset i. The value is 5 times bit 6 plus the offset. `sum` always uses this encoding with exactly one set bit in each field.
- R2: For legal operands, when `done` pulses, `sum` encodes (a + b + carry_in) mod 10 and `carry_out` is 1 exactly when a + b + carry_in is 10 or more.
- R3: If either operand has a count of set bits other than one in bits 6:5 or in bits 4:0, `done` and `err` are high after the accepting edge itself, `sum` is 7'b0100001 (zero), and `carry_out` is 0.
- R4: For legal operands, `done` is a one-cycle pulse that appears k clock edges after the accepting edge, where k is b's offset plus carry_in (k = 0 means on the accepting edge itself). It is never later than 5 edges after it.
- R5: `ready` is low while rotations remain outstanding. A `start` presented while `ready` is low is ignored and does not alter the result of the operation in flight.
- R6: A synchronous active-low reset sets `sum` to 7'b0100001, clears `carry_out`, `done` and `err`, and raises `ready`.
- R7: While the block is idle and no start is presented, `sum`, `carry_out` and `err` hold their values.
- R8: `err` is cleared by the next accepted start whose operands are legal.
- R9: After the accepting edge `sum` shows a plus 5 times b's upper bit (mod 10). Each later edge until `done` advances the shown value by exactly one, rotating bits 4:0 up by one position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to add the presented operands |
| ready | output | 1 | High when a request can be accepted |
| op_a | input | 7 | First operand, biquinary |
| op_b | input | 7 | Second operand, biquinary |
| carry_in | input | 1 | Incoming decimal carry |
| sum | output | 7 | Result digit, biquinary |
| carry_out | output | 1 | Outgoing decimal carry |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Set when an operand is corrupt, held until the next legal request |

## Verification
Every pair of decimal digits is added with both carry-in values. This separates a wrong parallel range step (results off by five) from a wrong ring rotation or range flip on wrap (results off by one or with a wrong carry). The cycle of `done` and the value shown on each intermediate cycle are tracked against the offset count. All 128 patterns of each operand are swept with the other held legal, so every single-bit and multi-bit corruption of either field must raise the error. The legal codes in those sweeps still have to add correctly. Directed cases cover a request while busy, an error held over idle cycles, and the error cleared by the next legal request.

// File: rtl/bq_pkg.sv
// Shared constants, the digit layout and helpers for the biquinary adder.
// Assumes a two-wire range field above a one-hot quinary ring.
package bq_pkg;
    localparam int Q_W   = 5;                  // quinary ring positions
    localparam int R_W   = 2;                  // range wires (upper, lower)
    localparam int D_W   = Q_W + R_W;          // digit width
    localparam int CNT_W = $clog2(Q_W + 1);    // holds offset plus carry

    typedef struct packed {
        logic [R_W-1:0] rng;   // [1] upper half, [0] lower half
        logic [Q_W-1:0] qui;   // bit i set = offset i
    } bq_digit_t;

    localparam bq_digit_t BQ_ZERO = '{rng: 2'b01, qui: Q_W'(1)};

    // Position of the set bit of a one-hot ring (0 when empty).
    function automatic logic [CNT_W-1:0] ring_offset(input logic [Q_W-1:0] q);
        logic [CNT_W-1:0] pos;
        pos = '0;
        for (int i = 0; i < Q_W; i++) begin
            if (q[i]) pos = pos | CNT_W'(i);
        end
        return pos;
    endfunction
endpackage

// File: rtl/bq_legal.sv
// Screens one digit: true only when each field has exactly one set wire.
// Assumes the field layout given by bq_pkg::bq_digit_t.
module bq_legal
    import bq_pkg::*;
(
    input  bq_digit_t dig,
    output logic      ok
);
    logic [CNT_W-1:0] rng_cnt;
    logic [CNT_W-1:0] qui_cnt;

    // Count set wires in each field separately.
    always_comb begin
        rng_cnt = '0;
        qui_cnt = '0;
        for (int i = 0; i < R_W; i++) rng_cnt = rng_cnt + CNT_W'(dig.rng[i]);
        for (int i = 0; i < Q_W; i++) qui_cnt = qui_cnt + CNT_W'(dig.qui[i]);
        ok = (rng_cnt == CNT_W'(1)) && (qui_cnt == CNT_W'(1));
    end
endmodule

// File: rtl/bq_step_ctrl.sv
// Sequencer: accepts a request, decides load or error clear, then
// issues one ring rotation per clock for the loaded step count.
// Assumes steps is only meaningful when legal is high.
module bq_step_ctrl
    import bq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             legal,
    input  logic [CNT_W-1:0] steps,
    output logic             ready,
    output logic             load,
    output logic             clear,
    output logic             inc,
    output logic             done,
    output logic             err
);
    logic             busy;
    logic [CNT_W-1:0] left;

    // Decode this cycle's action for the accumulator.
    always_comb begin
        ready = !busy;
        load  = !busy && start && legal;
        clear = !busy && start && !legal;
        inc   = busy;
    end

    // Track remaining rotations and produce the done and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                if (!legal) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end else begin
                    err <= 1'b0;
                    if (steps == '0) begin
                        done <= 1'b1;
                    end else begin
                        busy <= 1'b1;
                        left <= steps;
                    end
                end
            end else if (busy) begin
                left <= left - CNT_W'(1);
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bq_accum.sv
// Accumulator digit: a range pair and a one-hot ring. Load applies the
// jump of five in parallel; each increment rotates the ring one place
// and flips the range pair on wrap, raising carry when leaving upper.
// Assumes load, clear and inc are never needed together.
module bq_accum
    import bq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      clear,
    input  logic      inc,
    input  bq_digit_t a_dig,
    input  logic      b_upper,
    output bq_digit_t acc,
    output logic      cout
);
    // Update the digit and carry for clear, load or one ring step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= BQ_ZERO;
            cout <= 1'b0;
        end else if (clear) begin
            acc  <= BQ_ZERO;
            cout <= 1'b0;
        end else if (load) begin
            acc.qui <= a_dig.qui;
            if (b_upper) begin
                acc.rng <= {a_dig.rng[0], a_dig.rng[1]};
                cout    <= a_dig.rng[1];
            end else begin
                acc.rng <= a_dig.rng;
                cout    <= 1'b0;
            end
        end else if (inc) begin
            acc.qui <= {acc.qui[Q_W-2:0], acc.qui[Q_W-1]};
            if (acc.qui[Q_W-1]) begin
                acc.rng <= {acc.rng[0], acc.rng[1]};
                if (acc.rng[1]) cout <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bq_digit_adder.sv
// Top: biquinary digit adder by ring counting. Screens both operands,
// then drives the accumulator through the sequencer.
// Assumes operands are held steady only on the accepting edge.
module bq_digit_adder
    import bq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           ready,
    input  logic [D_W-1:0] op_a,
    input  logic [D_W-1:0] op_b,
    input  logic           carry_in,
    output logic [D_W-1:0] sum,
    output logic           carry_out,
    output logic           done,
    output logic           err
);
    localparam int N_OPND = 2;

    bq_digit_t        opnd [N_OPND];
    logic             opnd_ok [N_OPND];
    logic             both_ok;
    logic [CNT_W-1:0] steps;
    logic             load, clear, inc;
    bq_digit_t        acc;

    // Present both operands as typed digits.
    always_comb begin
        opnd[0] = bq_digit_t'(op_a);
        opnd[1] = bq_digit_t'(op_b);
    end

    // One legality screen per operand.
    for (genvar g = 0; g < N_OPND; g++) begin : g_screen
        bq_legal u_legal (.dig(opnd[g]), .ok(opnd_ok[g]));
    end

    // Combine screens and form the rotation count from offset plus carry.
    always_comb begin
        both_ok = opnd_ok[0] && opnd_ok[1];
        steps   = ring_offset(opnd[1].qui) + CNT_W'(carry_in);
    end

    bq_step_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .legal (both_ok),
        .steps (steps),
        .ready (ready),
        .load  (load),
        .clear (clear),
        .inc   (inc),
        .done  (done),
        .err   (err)
    );

    bq_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .clear   (clear),
        .inc     (inc),
        .a_dig   (opnd[0]),
        .b_upper (opnd[1].rng[1]),
        .acc     (acc),
        .cout    (carry_out)
    );

    assign sum = acc;
endmodule

// File: rtl/bq_digit_adder_chk.sv
// Property checker for bq_digit_adder, attached by bind below.
// Assumes the port names of the adder.
module bq_digit_adder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       ready,
    input logic [6:0] op_a,
    input logic [6:0] op_b,
    input logic       carry_in,
    input logic [6:0] sum,
    input logic       carry_out,
    input logic       done,
    input logic       err
);
    localparam int LAT_LIMIT = 6;   // counter value at the fifth edge after acceptance

    logic       ops_legal;
    logic [3:0] lat;

    // Independent legality view of the presented operands.
    assign ops_legal = ($countones(op_a[6:5]) == 1) && ($countones(op_a[4:0]) == 1) &&
                       ($countones(op_b[6:5]) == 1) && ($countones(op_b[4:0]) == 1);

    // Count edges since the accepting edge until done is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)               lat <= '0;
        else if (start && ready)  lat <= 4'd1;
        else if (done)            lat <= '0;
        else if (lat != '0)       lat <= lat + 4'd1;
    end

    p_sum_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(sum[6:5]) == 1) && ($countones(sum[4:0]) == 1));

    p_bad_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && !ops_legal) |=> (done && err && sum == 7'b0100001 && !carry_out));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lat <= 4'(LAT_LIMIT));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ($stable(sum) && $stable(carry_out) && $stable(err) && !done));

    p_ring_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (sum[4:0] == {$past(sum[3:0]), $past(sum[4])}));
endmodule

bind bq_digit_adder bq_digit_adder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .done      (done),
    .err       (err)
);

// File: tb/bq_digit_adder_test.sv
module bq_digit_adder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] op_a = 7'h21;
    logic [6:0] op_b = 7'h21;
    logic       carry_in = 1'b0;
    logic       ready, carry_out, done, err;
    logic [6:0] sum;

    int errors = 0;
    int checks = 0;
    int lat;
    int trace [0:20];
    int wd = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    bq_digit_adder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out), .done(done), .err(err)
    );

    function automatic logic [6:0] enc(input int v);
        logic [4:0] q;
        q = 5'b00001 << (v % 5);
        return {(v >= 5) ? 1'b1 : 1'b0, (v < 5) ? 1'b1 : 1'b0, q};
    endfunction

    function automatic bit legal7(input logic [6:0] d);
        int r, q;
        r = 0; q = 0;
        for (int i = 5; i < 7; i++) r += d[i];
        for (int i = 0; i < 5; i++) q += d[i];
        return (r == 1) && (q == 1);
    endfunction

    function automatic int dec(input logic [6:0] d);
        int off;
        off = 0;
        if (!legal7(d)) return -1;
        for (int i = 0; i < 5; i++) if (d[i]) off = i;
        return 5 * d[6] + off;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            summary();
        end
    end

    // Issue one request and record the shown value on each cycle until done.
    task automatic run_op(input logic [6:0] a, input logic [6:0] b, input logic c);
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        trace[1] = dec(sum);
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
            trace[lat] = dec(sum);
        end
    endtask

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        chk(sum == 7'b0100001, "R6 sum", sum, 7'b0100001);
        chk(!carry_out && !done && !err, "R6 flags", {carry_out, done, err}, 0);
        chk(ready == 1'b1, "R6 ready", ready, 1);
        rst_n = 1'b1;

        // R2, R4, R9: every digit pair with both carry values
        for (int av = 0; av < 10; av++) begin
            for (int bv = 0; bv < 10; bv++) begin
                for (int c = 0; c < 2; c++) begin
                    int k, tot, base;
                    bit steps_ok;
                    k = (bv % 5) + c;
                    tot = av + bv + c;
                    base = av + ((bv >= 5) ? 5 : 0);
                    run_op(enc(av), enc(bv), c[0]);
                    chk(lat == k + 1, "R4 latency", lat, k + 1);
                    chk(dec(sum) == tot % 10, "R2 sum", dec(sum), tot % 10);
                    chk(carry_out == (tot >= 10), "R2 carry", carry_out, tot >= 10);
                    chk(!err, "R3 no error on legal", err, 0);
                    steps_ok = 1'b1;
                    for (int j = 1; j <= k && j <= 20; j++)
                        if (trace[j] != (base + j - 1) % 10) steps_ok = 1'b0;
                    chk(steps_ok, "R9 per-step value", trace[1], base % 10);
                    @(negedge clk);
                    chk(!done, "R4 one-cycle done", done, 0);
                end
            end
        end

        // R1, R3: sweep every pattern of the first operand
        for (int p = 0; p < 128; p++) begin
            run_op(7'(p), enc(0), 1'b0);
            chk(lat == 1, "R3 sweep a latency", lat, 1);
            if (legal7(7'(p))) begin
                chk(!err && dec(sum) == dec(7'(p)), "R1 legal a code", dec(sum), dec(7'(p)));
            end else begin
                chk(err && sum == 7'b0100001 && !carry_out, "R3 illegal a", sum, 7'b0100001);
            end
        end

        // R1, R3: sweep every pattern of the second operand with carry in
        for (int p = 0; p < 128; p++) begin
            run_op(enc(9), 7'(p), 1'b1);
            if (legal7(7'(p))) begin
                int tot;
                tot = 9 + dec(7'(p)) + 1;
                chk(!err && dec(sum) == tot % 10 && carry_out, "R1 legal b code", dec(sum), tot % 10);
                chk(lat == (dec(7'(p)) % 5) + 2, "R4 sweep b latency", lat, (dec(7'(p)) % 5) + 2);
            end else begin
                chk(lat == 1 && err && sum == 7'b0100001 && !carry_out, "R3 illegal b", sum, 7'b0100001);
            end
        end

        // R7: error result holds while idle
        run_op(7'b1100001, enc(2), 1'b0);
        repeat (4) @(negedge clk);
        chk(err && sum == 7'b0100001 && !carry_out && !done, "R7 hold", sum, 7'b0100001);

        // R8: next legal request clears the error
        run_op(enc(2), enc(3), 1'b0);
        chk(!err && dec(sum) == 5, "R8 error cleared", dec(sum), 5);

        // R5: start while busy is ignored
        @(negedge clk);
        op_a = enc(3); op_b = enc(4); carry_in = 1'b1; start = 1'b1;
        @(negedge clk);
        chk(!ready, "R5 ready low while busy", ready, 0);
        op_a = enc(9); op_b = enc(9); carry_in = 1'b1;   // keep start high
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk(dec(sum) == 8 && !carry_out && lat == 6, "R5 busy start ignored", dec(sum), 8);

        summary();
    end
endmodule